// File: doc/BRIEF.md
# Four-Bit ECC Sector Correction Sequencer

This block runs the correction pass for one 512-byte sector after it has been read from flash. An external syndrome and error-locator engine does the arithmetic. The sequencer talks to that engine through a simple register-select port. It loads the stored check code into the engine and reads back four syndrome words. When the syndrome is not zero, it starts the error-address search and waits for the engine's state field to settle. It then fetches up to four address/value pairs, turns each reversed error address into a byte offset, and issues XOR-correction writes to the sector buffer.

A pulse on `start`, together with the ten stored code bytes, begins a pass. At the end the block raises `done` for one cycle. It reports either the number of bytes it corrected or a flag saying the sector cannot be corrected. The engine answers a read select with its data in the following cycle. The buffer applies each `buf_xor` mask to the byte at `buf_addr` in the cycle that `buf_we` is high.

Engine selects: 0 code load (write), 1 to 4 syndrome words 0 to 3, 5 status, 6 control, 7 first address pair, 8 second address pair, 9 first value pair, 10 second value pair.

Top module: `ecc4_fix_seq`

## Requirements
- R1: The code bytes are taken as one little-endian bit string, with byte 0 at `code_in[7:0]`. Code value j is bits 10j up to 10j+9 of that string, for j from 0 to 7.
- R2: The eight code values are written to select 0 as one burst of consecutive cycles, starting with value 7 and ending with value 0. Each value sits in bits [9:0] of the write data and the other data bits are zero.
- R3: Syndrome words 0 to 3 are read in order from selects 1 to 4, and each is masked with 0x03FF03FF. If all four masked words are zero, the pass ends with `fail`=0, a count of 0, and no further engine access.
- R4: When the syndrome is not zero, a read of select 7 comes first, to clear any stale result. A write to select 6 with data 0x00002000 (start bit 13) follows in the next cycle. The status word (select 5) is not read before that write.
- R5: The engine state is status bits [11:8]. After the start write, any state below 4 is treated as unreliable. No address pair is fetched until a state of 4 or more has been seen.
- R6: If no state of 4 or more is seen within SETTLE_LIMIT cycles after the start write, the sequencer moves on to normal polling anyway. No address fetch occurs earlier than SETTLE_LIMIT cycles after the start write.
- R7: During normal polling, state 0 ends the pass with a count of 0 and `fail`=0. State 1 ends it with `fail`=1 and a count of 0. States 2 and 3 start the fetch. A state of 4 or more causes another status read.
- R8: The number of errors is 1 plus status bits [17:16]. Errors 0 and 1 use selects 7 and 9, and errors 2 and 3 use selects 8 and 10. For each error the address register is read and then the value register. Even errors use bits [9:0] of the address and [7:0] of the value; odd errors use [25:16] and [23:16].
- R9: The byte offset of an error is 519 minus its 10-bit address. Only offsets below 512 produce a buffer write with the 8-bit error value, and only those are counted in `fix_count`.
- R10: `done` is high for exactly one cycle per pass. `fail` and `fix_count` hold their values from that cycle until the next accepted `start`. A `start` that arrives during a pass is ignored.
- R11: After reset, `done`, `fail`, `eng_req` and `buf_we` are 0 and `fix_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (accepted when idle) |
| code_in | input | 80 | Ten stored code bytes, byte 0 in bits [7:0] |
| eng_req | output | 1 | Engine access strobe |
| eng_we | output | 1 | Engine access is a write |
| eng_sel | output | 4 | Engine register select |
| eng_wdata | output | 32 | Engine write data |
| eng_rdata | input | 32 | Engine read data, valid the cycle after a read |
| buf_we | output | 1 | Sector buffer XOR write strobe |
| buf_addr | output | 9 | Byte offset in the sector |
| buf_xor | output | 8 | Mask XORed into the byte |
| done | output | 1 | One-cycle end-of-pass pulse |
| fail | output | 1 | Sector uncorrectable |
| fix_count | output | 3 | Number of bytes corrected |

## Verification
Each engine read takes two cycles: the select is issued in one cycle and the data is used in the next. Each buffer write takes one cycle of its own. `done` follows one cycle after the last decision, whether that decision was a syndrome capture, a status capture or the final buffer write. The bench keeps a queue of expected engine accesses and buffer writes, built from the requirements. On every falling clock edge it matches whatever access is present against the head of that queue, and checks that the queue is empty when `done` appears. Status reads form an open-ended polling loop, so they are not queued. Instead, the first address fetch after the start write is checked against the cycle distance since that write and against whether a busy state has already been served.

// File: rtl/ecc4_fix_pkg.sv
package ecc4_fix_pkg;

  localparam int NVAL        = 8;
  localparam int VAL_W       = 10;
  localparam int CODE_W      = NVAL * VAL_W;
  localparam int WORD_W      = 32;
  localparam int SECTOR      = 512;
  localparam int OFS_W       = $clog2(SECTOR);
  localparam int ADDR_BIAS   = SECTOR + 7;
  localparam logic [WORD_W-1:0] SYN_MASK  = 32'h03FF_03FF;
  localparam logic [WORD_W-1:0] KICK_WORD = 32'h0000_2000;

  typedef enum logic [3:0] {
    SEL_LOAD   = 4'd0,
    SEL_SYN0   = 4'd1,
    SEL_SYN1   = 4'd2,
    SEL_SYN2   = 4'd3,
    SEL_SYN3   = 4'd4,
    SEL_STAT   = 4'd5,
    SEL_CTRL   = 4'd6,
    SEL_ADDR_A = 4'd7,
    SEL_ADDR_B = 4'd8,
    SEL_VAL_A  = 4'd9,
    SEL_VAL_B  = 4'd10
  } eng_sel_e;

  function automatic logic [VAL_W-1:0] code_slice(input logic [CODE_W-1:0] bits, input int idx);
    return bits[idx*VAL_W +: VAL_W];
  endfunction

  function automatic logic syn_nonzero(input logic [WORD_W-1:0] w);
    return |(w & SYN_MASK);
  endfunction

  function automatic logic [3:0] stat_state(input logic [WORD_W-1:0] w);
    return w[11:8];
  endfunction

  function automatic logic [2:0] stat_errs(input logic [WORD_W-1:0] w);
    return {1'b0, w[17:16]} + 3'd1;
  endfunction

  function automatic logic [VAL_W-1:0] pick_addr(input logic [WORD_W-1:0] w, input logic upper);
    return upper ? w[25:16] : w[9:0];
  endfunction

  function automatic logic [7:0] pick_val(input logic [WORD_W-1:0] w, input logic upper);
    return upper ? w[23:16] : w[7:0];
  endfunction

endpackage

// File: rtl/ecc4_code_unpack.sv
module ecc4_code_unpack
  import ecc4_fix_pkg::*;
(
  input  logic [CODE_W-1:0]       code_bits,
  input  logic [$clog2(NVAL)-1:0] idx,
  output logic [VAL_W-1:0]        value
);
  logic [VAL_W-1:0] vals [NVAL];

  for (genvar g = 0; g < NVAL; g++) begin : g_val
    assign vals[g] = code_slice(code_bits, g);
  end

  assign value = vals[idx];
endmodule

// File: rtl/ecc4_settle_timer.sv
module ecc4_settle_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clear)             cnt <= '0;
    else if (run && cnt < LIM)  cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= LIM);
endmodule

// File: rtl/ecc4_err_map.sv
module ecc4_err_map
  import ecc4_fix_pkg::*;
(
  input  logic [VAL_W-1:0] err_addr,
  output logic [OFS_W-1:0] offset,
  output logic             in_sector
);
  localparam logic [VAL_W:0] BIAS = (VAL_W+1)'(ADDR_BIAS);
  localparam logic [VAL_W:0] LOW  = (VAL_W+1)'(ADDR_BIAS - SECTOR + 1);

  logic [VAL_W:0] diff;

  assign diff      = BIAS - {1'b0, err_addr};
  assign offset    = diff[OFS_W-1:0];
  assign in_sector = ({1'b0, err_addr} >= LOW) && ({1'b0, err_addr} <= BIAS);
endmodule

// File: rtl/ecc4_fix_seq.sv
module ecc4_fix_seq
  import ecc4_fix_pkg::*;
#(
  parameter int SETTLE_LIMIT = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code_in,
  output logic              eng_req,
  output logic              eng_we,
  output logic [3:0]        eng_sel,
  output logic [WORD_W-1:0] eng_wdata,
  input  logic [WORD_W-1:0] eng_rdata,
  output logic              buf_we,
  output logic [OFS_W-1:0]  buf_addr,
  output logic [7:0]        buf_xor,
  output logic              done,
  output logic              fail,
  output logic [2:0]        fix_count
);
  localparam int IW = $clog2(NVAL);

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_SYN_RD, S_SYN_CAP, S_CLR, S_KICK,
    S_SET_RD, S_SET_CAP, S_POL_RD, S_POL_CAP,
    S_ADR_RD, S_ADR_CAP, S_VAL_RD, S_VAL_CAP, S_FIX, S_DONE
  } st_e;

  st_e               st_q;
  logic [CODE_W-1:0] code_q;
  logic [IW-1:0]     ld_idx;
  logic [1:0]        syn_k;
  logic              syn_nz;
  logic [1:0]        err_i;
  logic [2:0]        err_n;
  logic [VAL_W-1:0]  addr_q;
  logic [7:0]        val_q;
  logic [2:0]        cnt_q;
  logic              fail_q;

  // named internal events
  logic             load_wr;
  logic [VAL_W-1:0] load_val;
  logic [3:0]       settle_state;
  logic             settle_expired;
  logic             settle_exit;
  logic [OFS_W-1:0] fix_ofs;
  logic             fix_ok;
  logic             last_err;

  ecc4_code_unpack u_unpack (
    .code_bits (code_q),
    .idx       (ld_idx),
    .value     (load_val)
  );

  ecc4_settle_timer #(.LIMIT(SETTLE_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (st_q == S_KICK),
    .run     (st_q == S_SET_RD || st_q == S_SET_CAP),
    .expired (settle_expired)
  );

  ecc4_err_map u_map (
    .err_addr  (addr_q),
    .offset    (fix_ofs),
    .in_sector (fix_ok)
  );

  assign load_wr      = (st_q == S_LOAD);
  assign settle_state = stat_state(eng_rdata);
  assign settle_exit  = (st_q == S_SET_CAP) && ((settle_state >= 4'd4) || settle_expired);
  assign last_err     = (({1'b0, err_i} + 3'd1) == err_n);

  // engine access decode
  always_comb begin
    eng_req   = 1'b0;
    eng_we    = 1'b0;
    eng_sel   = SEL_LOAD;
    eng_wdata = '0;
    unique case (st_q)
      S_LOAD: begin
        eng_req   = 1'b1;
        eng_we    = 1'b1;
        eng_sel   = SEL_LOAD;
        eng_wdata = {{(WORD_W-VAL_W){1'b0}}, load_val};
      end
      S_SYN_RD: begin
        eng_req = 1'b1;
        eng_sel = 4'(SEL_SYN0) + {2'b00, syn_k};
      end
      S_CLR: begin
        eng_req = 1'b1;
        eng_sel = SEL_ADDR_A;
      end
      S_KICK: begin
        eng_req   = 1'b1;
        eng_we    = 1'b1;
        eng_sel   = SEL_CTRL;
        eng_wdata = KICK_WORD;
      end
      S_SET_RD, S_POL_RD: begin
        eng_req = 1'b1;
        eng_sel = SEL_STAT;
      end
      S_ADR_RD: begin
        eng_req = 1'b1;
        eng_sel = err_i[1] ? SEL_ADDR_B : SEL_ADDR_A;
      end
      S_VAL_RD: begin
        eng_req = 1'b1;
        eng_sel = err_i[1] ? SEL_VAL_B : SEL_VAL_A;
      end
      default: ;
    endcase
  end

  assign buf_we    = (st_q == S_FIX) && fix_ok;
  assign buf_addr  = fix_ofs;
  assign buf_xor   = val_q;
  assign done      = (st_q == S_DONE);
  assign fail      = fail_q;
  assign fix_count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      code_q <= '0;
      ld_idx <= '0;
      syn_k  <= '0;
      syn_nz <= 1'b0;
      err_i  <= '0;
      err_n  <= '0;
      addr_q <= '0;
      val_q  <= '0;
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start) begin
          code_q <= code_in;
          ld_idx <= IW'(NVAL - 1);
          cnt_q  <= '0;
          fail_q <= 1'b0;
          st_q   <= S_LOAD;
        end
        S_LOAD: begin
          if (ld_idx == '0) begin
            syn_k  <= '0;
            syn_nz <= 1'b0;
            st_q   <= S_SYN_RD;
          end else begin
            ld_idx <= ld_idx - 1'b1;
          end
        end
        S_SYN_RD: st_q <= S_SYN_CAP;
        S_SYN_CAP: begin
          syn_nz <= syn_nz | syn_nonzero(eng_rdata);
          if (syn_k == 2'd3) begin
            st_q <= (syn_nz | syn_nonzero(eng_rdata)) ? S_CLR : S_DONE;
          end else begin
            syn_k <= syn_k + 1'b1;
            st_q  <= S_SYN_RD;
          end
        end
        S_CLR:    st_q <= S_KICK;
        S_KICK:   st_q <= S_SET_RD;
        S_SET_RD: st_q <= S_SET_CAP;
        S_SET_CAP: st_q <= settle_exit ? S_POL_RD : S_SET_RD;
        S_POL_RD: st_q <= S_POL_CAP;
        S_POL_CAP: begin
          unique case (settle_state)
            4'd0: st_q <= S_DONE;
            4'd1: begin
              fail_q <= 1'b1;
              st_q   <= S_DONE;
            end
            4'd2, 4'd3: begin
              err_n <= stat_errs(eng_rdata);
              err_i <= '0;
              st_q  <= S_ADR_RD;
            end
            default: st_q <= S_POL_RD;
          endcase
        end
        S_ADR_RD: st_q <= S_ADR_CAP;
        S_ADR_CAP: begin
          addr_q <= pick_addr(eng_rdata, err_i[0]);
          st_q   <= S_VAL_RD;
        end
        S_VAL_RD: st_q <= S_VAL_CAP;
        S_VAL_CAP: begin
          val_q <= pick_val(eng_rdata, err_i[0]);
          st_q  <= S_FIX;
        end
        S_FIX: begin
          if (fix_ok) cnt_q <= cnt_q + 1'b1;
          if (last_err) begin
            st_q <= S_DONE;
          end else begin
            err_i <= err_i + 1'b1;
            st_q  <= S_ADR_RD;
          end
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecc4_fix_chk.sv
module ecc4_fix_chk
  import ecc4_fix_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       eng_req,
  input logic       eng_we,
  input logic [3:0] eng_sel,
  input logic       load_wr,
  input logic       done,
  input logic       fail,
  input logic [2:0] fix_count
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  fail_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (fix_count == 3'd0));

  // R8
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fix_count <= 3'd4));

  // R4
  clear_before_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_we && eng_sel == SEL_CTRL) |->
      $past(eng_req && !eng_we && eng_sel == SEL_ADDR_A));

  // R2
  load_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (load_wr || (eng_req && !eng_we && eng_sel == SEL_SYN0)));
endmodule

bind ecc4_fix_seq ecc4_fix_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .eng_req   (eng_req),
  .eng_we    (eng_we),
  .eng_sel   (eng_sel),
  .load_wr   (load_wr),
  .done      (done),
  .fail      (fail),
  .fix_count (fix_count)
);

// File: tb/tb_ecc4_fix_seq.sv
`timescale 1ns/1ps
module tb_ecc4_fix_seq;
  localparam int LIM = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [79:0] code_in = '0;
  logic        eng_req, eng_we, buf_we, done, fail;
  logic [3:0]  eng_sel;
  logic [31:0] eng_wdata;
  logic [31:0] eng_rdata;
  logic [8:0]  buf_addr;
  logic [7:0]  buf_xor;
  logic [2:0]  fix_count;

  always #5 clk = ~clk;

  ecc4_fix_seq #(.SETTLE_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .code_in(code_in),
    .eng_req(eng_req), .eng_we(eng_we), .eng_sel(eng_sel),
    .eng_wdata(eng_wdata), .eng_rdata(eng_rdata),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_xor(buf_xor),
    .done(done), .fail(fail), .fix_count(fix_count)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- engine model ----------------
  logic [31:0] syn [4];
  logic [31:0] reg_a, reg_b, val_a, val_b;
  int          n_false, n_busy;
  logic [3:0]  fin_state;
  logic [1:0]  cnt_fld;
  int          stat_reads;

  always_ff @(posedge clk) begin
    if (eng_req && eng_we && eng_sel == 4'd6) stat_reads <= 0;
    if (eng_req && !eng_we) begin
      case (eng_sel)
        4'd1, 4'd2, 4'd3, 4'd4: eng_rdata <= syn[eng_sel - 4'd1];
        4'd5: begin
          if (stat_reads < n_false)
            eng_rdata <= {14'd0, cnt_fld, 4'd0, 4'd3, 8'h01};
          else if (stat_reads < n_false + n_busy)
            eng_rdata <= {14'd0, 2'd0, 4'd0, 4'd5, 8'h00};
          else
            eng_rdata <= {14'd0, cnt_fld, 4'd0, fin_state, 8'h01};
          stat_reads <= stat_reads + 1;
        end
        4'd7:  eng_rdata <= reg_a;
        4'd8:  eng_rdata <= reg_b;
        4'd9:  eng_rdata <= val_a;
        4'd10: eng_rdata <= val_b;
        default: eng_rdata <= 32'hDEAD_BEEF;
      endcase
    end
  end

  // ---------------- expectation queues ----------------
  logic [36:0] exp_q[$];
  logic [16:0] buf_q[$];
  bit    kicked, seen_busy, scen_active, exp_fail;
  int    cyc, kick_cyc, exp_cnt;
  int    done_seen;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && scen_active) begin
      if (eng_req) begin
        if (!eng_we && eng_sel == 4'd5) begin
          // R4: no status read before the start write
          if (!kicked) check(0, "R4 status before kick", eng_sel, 6);
          if (stat_reads >= n_false) seen_busy = 1;
        end else begin
          if (kicked && !eng_we && (eng_sel == 4'd7 || eng_sel == 4'd8)) begin
            // R5 / R6: fetch only after busy state seen or after timeout
            check(seen_busy || (cyc - kick_cyc >= LIM), "R5 R6 early fetch", cyc - kick_cyc, LIM);
            kicked = 0; // one gate check per pass
            seen_busy = 1;
          end
          if (exp_q.size() == 0) check(0, "R2 R3 R8 unexpected access", {eng_we, eng_sel}, 0);
          else begin
            logic [36:0] e;
            e = exp_q.pop_front();
            check({eng_we, eng_sel, eng_wdata} == e, "R1 R2 R3 R4 R8 access", {eng_we, eng_sel, eng_wdata}, e);
          end
          if (eng_we && eng_sel == 4'd6) begin
            kicked = 1;
            kick_cyc = cyc;
          end
        end
      end
      if (buf_we) begin
        if (buf_q.size() == 0) check(0, "R9 unexpected buffer write", {buf_addr, buf_xor}, 0);
        else begin
          logic [16:0] b;
          b = buf_q.pop_front();
          check({buf_addr, buf_xor} == b, "R9 buffer write", {buf_addr, buf_xor}, b);
        end
      end
      if (done) begin
        done_seen++;
        check(exp_q.size() == 0 && buf_q.size() == 0, "R3 R7 R8 pending at done", exp_q.size() + buf_q.size(), 0);
        check(fail == exp_fail, "R7 fail flag", fail, exp_fail);
        check(fix_count == 3'(exp_cnt), "R9 fix count", fix_count, exp_cnt);
      end
    end
  end

  // code value j taken bit by bit from the byte array
  function automatic logic [9:0] ref_val(input logic [7:0] by [10], input int j);
    logic [9:0] v;
    for (int b = 0; b < 10; b++) v[b] = by[(10*j + b) / 8][(10*j + b) % 8];
    return v;
  endfunction

  task automatic run_pass(input logic [7:0] by [10], input logic [31:0] s0, s1, s2, s3,
                          input int nf, input int nb, input logic [3:0] fin, input logic [1:0] cf,
                          input logic [9:0] ea [4], input logic [7:0] ev [4], input bit stray_start);
    bit dirty;
    int nerr;
    syn[0] = s0; syn[1] = s1; syn[2] = s2; syn[3] = s3;
    n_false = nf; n_busy = nb; fin_state = fin; cnt_fld = cf;
    reg_a = {6'd0, ea[1], 6'd0, ea[0]};
    reg_b = {6'd0, ea[3], 6'd0, ea[2]};
    val_a = {8'd0, ev[1], 8'd0, ev[0]};
    val_b = {8'd0, ev[3], 8'd0, ev[2]};
    exp_q.delete(); buf_q.delete();
    exp_fail = 0; exp_cnt = 0;
    for (int j = 7; j >= 0; j--) exp_q.push_back({1'b1, 4'd0, 22'd0, ref_val(by, j)});
    for (int k = 0; k < 4; k++) exp_q.push_back({1'b0, 4'(k + 1), 32'd0});
    dirty = ((s0 | s1 | s2 | s3) & 32'h03FF03FF) != 0;
    if (dirty) begin
      exp_q.push_back({1'b0, 4'd7, 32'd0});
      exp_q.push_back({1'b1, 4'd6, 32'h0000_2000});
      if (fin == 4'd1) exp_fail = 1;
      else if (fin == 4'd2 || fin == 4'd3) begin
        nerr = int'(cf) + 1;
        for (int i = 0; i < nerr; i++) begin
          int ofs;
          exp_q.push_back({1'b0, (i < 2) ? 4'd7 : 4'd8, 32'd0});
          exp_q.push_back({1'b0, (i < 2) ? 4'd9 : 4'd10, 32'd0});
          ofs = 519 - int'(ea[i]);
          if (ofs >= 0 && ofs < 512) begin
            buf_q.push_back({9'(ofs), ev[i]});
            exp_cnt++;
          end
        end
      end
    end
    kicked = 0; seen_busy = 0; done_seen = 0;
    for (int i = 0; i < 10; i++) code_in[8*i +: 8] = by[i];
    scen_active = 1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int t = 0; t < 3000 && done_seen == 0; t++) begin
      if (stray_start && t == 5) start = 1;
      if (stray_start && t == 6) start = 0;
      @(negedge clk);
    end
    if (done_seen == 0) check(0, "watchdog", 0, 1);
    // R10: single pulse, results held afterwards
    repeat (2) @(posedge clk);
    #1;
    check(done == 0, "R10 done pulse length", done, 0);
    check(fix_count == 3'(exp_cnt) && fail == exp_fail, "R10 results held", {fail, fix_count}, {exp_fail, 3'(exp_cnt)});
    check(eng_req == 0, "R10 idle after done (stray start ignored)", eng_req, 0);
    scen_active = 0;
  endtask

  initial begin
    logic [7:0] by [10];
    logic [9:0] ea [4];
    logic [7:0] ev [4];
    stat_reads = 0; cyc = 0; eng_rdata = '0;
    scen_active = 0;
    for (int i = 0; i < 4; i++) begin ea[i] = '0; ev[i] = '0; syn[i] = '0; end
    repeat (3) @(negedge clk);
    // R11: reset state
    check(done == 0 && fail == 0 && eng_req == 0 && buf_we == 0 && fix_count == 0,
          "R11 reset outputs", {done, fail, eng_req, buf_we, fix_count}, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R3: clean sector, distinct code pattern
    for (int i = 0; i < 10; i++) by[i] = 8'(8'h13 * (i + 1) + 8'h5A);
    run_pass(by, 0, 0, 0, 0, 0, 0, 4'd0, 2'd0, ea, ev, 0);

    // R3: syndrome bits outside the mask are ignored
    for (int i = 0; i < 10; i++) by[i] = 8'(8'hA5 ^ (i * 37));
    run_pass(by, 32'hFC00_FC00, 32'hFC00_0000, 32'h0000_FC00, 32'hFC00_FC00, 0, 0, 4'd0, 2'd0, ea, ev, 0);

    // R5 R8 R9 R10: spurious state 3, four errors, one in parity area, stray start
    ea[0] = 10'd519; ev[0] = 8'h81;
    ea[1] = 10'd8;   ev[1] = 8'h42;
    ea[2] = 10'd5;   ev[2] = 8'h24;
    ea[3] = 10'd300; ev[3] = 8'h18;
    run_pass(by, 0, 0, 32'h0000_0004, 0, 3, 2, 4'd2, 2'd3, ea, ev, 1);

    // R7: uncorrectable
    run_pass(by, 32'h0001_0000, 0, 0, 0, 1, 1, 4'd1, 2'd2, ea, ev, 0);

    // R7: state 0 after busy
    run_pass(by, 0, 32'h0000_0100, 0, 0, 0, 3, 4'd0, 2'd0, ea, ev, 0);

    // R6: state never leaves 3, timeout path, one error
    ea[0] = 10'd10; ev[0] = 8'hF0;
    run_pass(by, 32'h0000_0001, 0, 0, 0, 100000, 0, 4'd3, 2'd0, ea, ev, 0);

    // R8 R9: two errors, odd one from upper half, address 0 skipped
    ea[0] = 10'd100; ev[0] = 8'h0F;
    ea[1] = 10'd0;   ev[1] = 8'h77;
    run_pass(by, 0, 0, 0, 32'h0200_0000, 0, 1, 4'd3, 2'd1, ea, ev, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule